// File: doc/BRIEF.md
# Frame Size Statistics Counters

This block keeps traffic statistics for one direction of a network port. Each time a frame finishes, the datapath raises a one-cycle done strobe together with the frame length in bytes. On that clock edge the block counts the frame, adds its length to two byte accumulators, counts it as a good frame and bumps exactly one of eight size-histogram counters.

All counters live in one indexed counter file. Software reads any counter through a combinational read port and can preset any counter with a write strobe. The entries above the histogram are plain writable storage that frame traffic never touches. Two instances serve transmit and receive.

Top module: `frame_stat_counters`

## Requirements
- R1: On each clock edge with `frame_done` high, the packet counter (index 0) increases by one and the octet counter (index 1) increases by `frame_len`.
- R2: On the same edge, the good-frame counter (index 2) increases by one and the good-octet counter (index 3) increases by `frame_len`.
- R3: Each frame increments exactly one histogram counter. The counters sit at indices 4 to 11 in this order: below 64 bytes, exactly 64, 65 to 127, 128 to 255, 256 to 511, 512 to 1023, 1024 to 2047, and 2048 or more.
- R4: Lengths of 0, 63, 64, 65, 127, 128, 2047, 2048 and the largest `frame_len` value each land in the bin that R3 gives.
- R5: Counters at index 12 and above change only through software writes. Frames never alter them.
- R6: When `sw_wr` is high at a clock edge, the counter at `sw_idx` takes the value of `sw_wdata`. `sw_rdata` always shows the counter at `sw_idx` without delay.
- R7: When a software write and a frame update hit the same counter on the same edge, the written value is kept. All other counters still take the frame update.
- R8: Counters wrap modulo 2^32 and do not saturate.
- R9: After reset every counter reads zero.
- R10: With `frame_done` and `sw_wr` both low, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle strobe when a frame completes |
| frame_len | input | LEN_W (16) | Length in bytes of the completed frame |
| sw_wr | input | 1 | Software write strobe |
| sw_idx | input | IDX_W (5) | Counter index for read and write |
| sw_wdata | input | CW (32) | Value to load on a software write |
| sw_rdata | output | CW (32) | Current value of the counter at `sw_idx` |

## Verification
The bound assertions check the following on every cycle:
- Each frame selects exactly one histogram bin.
- The packet, octet and good-frame counters step correctly when no write is present.
- Counters hold while the block is idle.
- The first storage entry ignores frames.
- A write to the packet counter wins over a frame on the same edge.

Only the bench scenarios show the remaining behaviour:
- The bin boundaries at each length edge.
- Wrap-around from preset values.
- Collisions on other indices.
- The reset contents of the whole file.

For these, the bench compares every counter against a reference model after directed and random traffic.

// File: rtl/stat_pkg.sv
package stat_pkg;
   localparam int IDX_PKT      = 0;
   localparam int IDX_OCT      = 1;
   localparam int IDX_GOOD     = 2;
   localparam int IDX_GOOD_OCT = 3;
   localparam int BIN_BASE     = 4;
   localparam int NUM_BINS     = 8;
   localparam int FIRST_STORE  = BIN_BASE + NUM_BINS;

   typedef enum logic [1:0] {
      ADD_NONE = 2'd0,
      ADD_ONE  = 2'd1,
      ADD_LEN  = 2'd2
   } add_kind_e;
endpackage

// File: rtl/stat_bin_sel.sv
module stat_bin_sel #(
   parameter int LEN_W = 16
) (
   input  logic [LEN_W-1:0]             frame_len,
   output logic [stat_pkg::NUM_BINS-1:0] bin_hit
);
   localparam int NB = stat_pkg::NUM_BINS;

   if (LEN_W < 12) begin : g_len_chk
      $error("stat_bin_sel: LEN_W must reach 2048");
   end

   assign bin_hit[0] = frame_len < LEN_W'(64);
   assign bin_hit[1] = frame_len == LEN_W'(64);
   assign bin_hit[2] = (frame_len > LEN_W'(64)) && (frame_len < LEN_W'(128));

   for (genvar k = 3; k < NB - 1; k++) begin : g_pow_bin
      assign bin_hit[k] = (frame_len >= LEN_W'(1 << (k + 4))) &&
                          (frame_len <  LEN_W'(1 << (k + 5)));
   end

   assign bin_hit[NB-1] = frame_len >= LEN_W'(2048);
endmodule

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_data,
   input  logic          add_en,
   input  logic [CW-1:0] add_val,
   output logic [CW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= wr_data;
      else if (add_en)
         q <= q + add_val;
   end
endmodule

// File: rtl/frame_stat_counters.sv
module frame_stat_counters #(
   parameter int CW       = 32,
   parameter int LEN_W    = 16,
   parameter int NUM_CNT  = 32,
   localparam int IDX_W   = $clog2(NUM_CNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_done,
   input  logic [LEN_W-1:0] frame_len,
   input  logic             sw_wr,
   input  logic [IDX_W-1:0] sw_idx,
   input  logic [CW-1:0]    sw_wdata,
   output logic [CW-1:0]    sw_rdata
);
   import stat_pkg::*;

   if (NUM_CNT < FIRST_STORE) begin : g_cnt_chk
      $error("frame_stat_counters: NUM_CNT too small for the counter map");
   end
   if ((1 << IDX_W) != NUM_CNT) begin : g_pow_chk
      $error("frame_stat_counters: NUM_CNT must be a power of two");
   end
   if (CW <= LEN_W) begin : g_cw_chk
      $error("frame_stat_counters: CW must exceed LEN_W");
   end

   logic [NUM_BINS-1:0] bin_hit;
   logic [CW-1:0]       len_ext;
   logic [CW-1:0]       cnt_q [NUM_CNT];

   assign len_ext = {{(CW-LEN_W){1'b0}}, frame_len};

   stat_bin_sel #(.LEN_W(LEN_W)) u_bins (
      .frame_len (frame_len),
      .bin_hit   (bin_hit)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cell
      logic          add_en;
      logic [CW-1:0] add_val;
      logic          wr_hit;

      if (i == IDX_PKT || i == IDX_GOOD) begin : g_one
         assign add_en  = frame_done;
         assign add_val = CW'(1);
      end else if (i == IDX_OCT || i == IDX_GOOD_OCT) begin : g_len
         assign add_en  = frame_done;
         assign add_val = len_ext;
      end else if (i >= BIN_BASE && i < FIRST_STORE) begin : g_bin
         assign add_en  = frame_done && bin_hit[i-BIN_BASE];
         assign add_val = CW'(1);
      end else begin : g_store
         assign add_en  = 1'b0;
         assign add_val = '0;
      end

      assign wr_hit = sw_wr && (sw_idx == IDX_W'(i));

      stat_ctr_cell #(.CW(CW)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_hit),
         .wr_data (sw_wdata),
         .add_en  (add_en),
         .add_val (add_val),
         .q       (cnt_q[i])
      );
   end

   assign sw_rdata = cnt_q[sw_idx];
endmodule

// File: rtl/stat_chk.sv
module stat_chk #(
   parameter int CW    = 32,
   parameter int LEN_W = 16,
   parameter int IDX_W = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        frame_done,
   input logic [LEN_W-1:0]            frame_len,
   input logic                        sw_wr,
   input logic [IDX_W-1:0]            sw_idx,
   input logic [CW-1:0]               sw_wdata,
   input logic [stat_pkg::NUM_BINS-1:0] bin_hit,
   input logic [CW-1:0]               pkt,
   input logic [CW-1:0]               oct,
   input logic [CW-1:0]               good,
   input logic [CW-1:0]               store0
);
   assert_one_bin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $countones(bin_hit) == 1);

   assert_pkt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !sw_wr) |=> pkt == $past(pkt) + CW'(1));

   assert_oct_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !sw_wr) |=> oct == $past(oct) + CW'($past(frame_len)));

   assert_good_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !sw_wr) |=> good == $past(good) + CW'(1));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !sw_wr) |=> $stable(pkt) && $stable(oct) && $stable(good));

   assert_store_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr |=> $stable(store0));

   assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && sw_idx == IDX_W'(stat_pkg::IDX_PKT)) |=> pkt == $past(sw_wdata));
endmodule

bind frame_stat_counters stat_chk #(.CW(CW), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_done (frame_done),
   .frame_len  (frame_len),
   .sw_wr      (sw_wr),
   .sw_idx     (sw_idx),
   .sw_wdata   (sw_wdata),
   .bin_hit    (bin_hit),
   .pkt        (cnt_q[stat_pkg::IDX_PKT]),
   .oct        (cnt_q[stat_pkg::IDX_OCT]),
   .good       (cnt_q[stat_pkg::IDX_GOOD]),
   .store0     (cnt_q[stat_pkg::FIRST_STORE])
);

// File: tb/sim_frame_stat_counters.sv
`timescale 1ns/1ps
module sim_frame_stat_counters;
   localparam int CW = 32, LEN_W = 16, NUM_CNT = 32, IDX_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_done = 1'b0;
   logic [LEN_W-1:0] frame_len = '0;
   logic             sw_wr = 1'b0;
   logic [IDX_W-1:0] sw_idx = '0;
   logic [CW-1:0]    sw_wdata = '0;
   logic [CW-1:0]    sw_rdata;

   logic [CW-1:0] exp_cnt [NUM_CNT];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   frame_stat_counters #(.CW(CW), .LEN_W(LEN_W), .NUM_CNT(NUM_CNT)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_len(frame_len),
      .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
   );

   function automatic int bin_of(input int len);
      if (len < 64)        return 0;
      else if (len == 64)  return 1;
      else if (len < 128)  return 2;
      else if (len < 256)  return 3;
      else if (len < 512)  return 4;
      else if (len < 1024) return 5;
      else if (len < 2048) return 6;
      else                 return 7;
   endfunction

   task automatic step(input bit fd, input int len, input bit wr,
                       input int idx, input logic [CW-1:0] wd);
      @(negedge clk);
      frame_done = fd; frame_len = LEN_W'(len);
      sw_wr = wr; sw_idx = IDX_W'(idx); sw_wdata = wd;
      @(posedge clk);
      if (fd) begin
         exp_cnt[0] = exp_cnt[0] + 1;
         exp_cnt[1] = exp_cnt[1] + CW'(len);
         exp_cnt[2] = exp_cnt[2] + 1;
         exp_cnt[3] = exp_cnt[3] + CW'(len);
         exp_cnt[4 + bin_of(len)] = exp_cnt[4 + bin_of(len)] + 1;
      end
      if (wr) exp_cnt[idx] = wd;
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < NUM_CNT; i++) begin
         @(negedge clk);
         frame_done = 1'b0; sw_wr = 1'b0; sw_idx = IDX_W'(i);
         #1;
         checks++;
         if (sw_rdata !== exp_cnt[i]) begin
            errors++;
            $display("FAIL %s index %0d actual %0h expected %0h", req, i, sw_rdata, exp_cnt[i]);
         end
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int lens [14] = '{0, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048};
      for (int i = 0; i < NUM_CNT; i++) exp_cnt[i] = '0;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      check_all("R9 reset");

      foreach (lens[i]) begin
         step(1, lens[i], 0, 0, '0);
         check_all("R3 R4 bin boundary");
      end
      step(1, 65535, 0, 0, '0);
      check_all("R4 max length");

      repeat (5) step(0, 0, 0, 0, '0);
      check_all("R10 idle hold");

      step(0, 0, 1, 5, 32'hA5A5_0001);
      step(0, 0, 1, 20, 32'hDEAD_BEEF);
      check_all("R6 write");
      step(1, 300, 0, 0, '0);
      step(1, 40, 0, 0, '0);
      check_all("R5 storage untouched");

      step(1, 100, 1, 0, 32'h1234);
      check_all("R7 write wins pkt");
      step(1, 700, 1, 9, 32'h77);
      check_all("R7 write wins bin");

      step(0, 0, 1, 1, 32'hFFFF_FFF0);
      step(0, 0, 1, 0, 32'hFFFF_FFFF);
      step(1, 32, 0, 0, '0);
      check_all("R8 wrap");

      for (int n = 0; n < 400; n++) begin
         int r = int'($urandom % 4);
         int len = (r == 0) ? int'($urandom % 200) :
                   (r == 1) ? int'($urandom % 2100) :
                   (r == 2) ? int'($urandom % 65536) : 64;
         bit fd = ($urandom % 5) != 0;
         bit wr = ($urandom % 6) == 0;
         step(fd, len, wr, int'($urandom % NUM_CNT), $urandom);
         if (n % 40 == 39) check_all("R1 R2 random");
      end
      check_all("R1 R2 final");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule